// File: doc/BRIEF.md
# Region Access Permission Checker

The checker sits beside one or more bus access paths and decides, in the same cycle as the access, whether each access is allowed. Software programs a table of address windows. Each window has an inclusive lower and upper bound, an enable bit, and read/write/execute rights for each of the three untrusted security modes. The mode of an access is looked up from a per-master table, indexed by the 5-bit master ID that travels with the access. Mode 0 is trusted and is never checked.

An access that is refused is flagged as blocked. The path's exception record then latches the cause, the master ID, the mode, a bitmap of the enabled windows that contained the address, and the address itself. The record holds that first fault until software clears it. While the record is set, a per-path interrupt is raised if that path's interrupt is enabled. Configuration and clearing use a simple word-addressed write port with a combinational read port.

Top module: `perm_checker`

## Requirements
- R1: After reset, every configuration register, every exception status, every captured field and every interrupt reads zero. With its path filter bit at zero, an access is allowed.
- R2: Window n contains address A only when enable bit n (register 0x000, bit n) is set and start(n) <= A <= end(n), with both bounds inclusive. start(n) is at 0x100+16n and end(n) is at 0x104+16n. A disabled window never grants.
- R3: The rights for untrusted mode m are held in bits [4(m-1)+2 : 4(m-1)] of the attribute register at 0x108+16n, with bit 0 = read, bit 1 = write and bit 2 = execute within each field. The access kind is encoded 0 = read, 1 = write, 2 = execute and 3 = reserved, which is never granted. An untrusted access is allowed when any window that contains its address grants its kind.
- R4: The mode of an access is the 2-bit value stored at 0x300+4*ID for its master ID. Mode 0 accesses are always allowed and never record an exception.
- R5: Bit p of register 0x004 enables checking on path p. When that bit is clear, every access on path p is allowed and no exception is recorded.
- R6: A refused access has acc_block high and acc_allow low in its own cycle. From the next cycle, that path's status register (0x200+16p) reads 1 when no window contained the address, or 2 when a window contained it but denied the right. Paths record independently.
- R7: The first info register (0x208+16p) holds the master ID in bits 22:18, the mode in bits 17:16 and the window hit bitmap in bits 15:0. The bitmap is zero when no window matched. The second info register (0x20C+16p) holds the faulting address.
- R8: While a path's status is non-zero, later violations on that path are still blocked, but they change neither the status nor the captured info.
- R9: Writing a value with bit 0 set to 0x204+16p clears that path's status and info. A write with bit 0 clear has no effect. If a clear and a violation on the same path fall in one cycle, the new violation is recorded.
- R10: irq[p] is high exactly while the status of path p is non-zero and bit p of register 0x008 is set.
- R11: Window bounds, window attributes and mode-table entries read back at their own addresses. Unused attribute bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Byte address for register writes and reads (word aligned) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| acc_valid | input | NUM_PATHS | Access present, one bit per path |
| acc_addr | input | NUM_PATHS*ADDR_W | Access address per path |
| acc_id | input | NUM_PATHS*5 | Master ID per path |
| acc_kind | input | NUM_PATHS*2 | Access kind per path (0 read, 1 write, 2 execute) |
| acc_allow | output | NUM_PATHS | Access allowed on the path this cycle |
| acc_block | output | NUM_PATHS | Access refused on the path this cycle |
| irq | output | NUM_PATHS | Per-path exception interrupt |

## Verification
On one path, a software clear and a fresh violation can land in the same cycle. The bench provokes this by driving the clear write and a denied access on the same falling edge. It then reads the status and the first info register, expecting them to hold the new fault rather than zero. Two paths faulting with different causes also checks that the records stay separate: one path shows status 2 with its interrupt masked, while the other shows status 1 with its interrupt enabled.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;

  localparam int ID_W   = 5;
  localparam int MODE_W = 2;
  localparam int NMAST  = 1 << ID_W;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  localparam logic [1:0] EXC_NONE    = 2'b00;
  localparam logic [1:0] EXC_NOMATCH = 2'b01;
  localparam logic [1:0] EXC_DENIED  = 2'b10;

  localparam logic [3:0] BLK_CTRL   = 4'h0;
  localparam logic [3:0] BLK_REGION = 4'h1;
  localparam logic [3:0] BLK_PATH   = 4'h2;
  localparam logic [3:0] BLK_MODE   = 4'h3;

endpackage

// File: rtl/perm_region_eval.sv
module perm_region_eval
  import perm_chk_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32
) (
  input  logic [AW-1:0]                 addr,
  input  logic [MODE_W-1:0]             mode,
  input  logic [1:0]                    kind,
  input  logic [NREG-1:0][AW-1:0]       rg_lo,
  input  logic [NREG-1:0][AW-1:0]       rg_hi,
  input  logic [NREG-1:0][2:0][2:0]     rg_attr,
  input  logic [NREG-1:0]               rg_en,
  output logic [NREG-1:0]               hit_map,
  output logic                          ok,
  output logic [1:0]                    exc_kind
);

  logic [NREG-1:0] grant;

  for (genvar r = 0; r < NREG; r++) begin : g_rg
    logic [2:0] rights;
    logic       right;

    always_comb begin
      case (mode)
        2'd1:    rights = rg_attr[r][0];
        2'd2:    rights = rg_attr[r][1];
        2'd3:    rights = rg_attr[r][2];
        default: rights = 3'b000;
      endcase
      case (kind)
        KIND_READ:  right = rights[0];
        KIND_WRITE: right = rights[1];
        KIND_EXEC:  right = rights[2];
        default:    right = 1'b0;
      endcase
    end

    assign hit_map[r] = rg_en[r] && (addr >= rg_lo[r]) && (addr <= rg_hi[r]);
    assign grant[r]   = hit_map[r] & right;
  end

  assign ok       = (mode == 2'd0) || (|grant);
  assign exc_kind = (|hit_map) ? EXC_DENIED : EXC_NOMATCH;

endmodule

// File: rtl/perm_exc_rec.sv
module perm_exc_rec
  import perm_chk_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol,
  input  logic              clr,
  input  logic [1:0]        type_in,
  input  logic [ID_W-1:0]   id_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [NREG-1:0]   map_in,
  input  logic [AW-1:0]     addr_in,
  output logic [1:0]        status,
  output logic [ID_W-1:0]   rec_id,
  output logic [MODE_W-1:0] rec_mode,
  output logic [NREG-1:0]   rec_map,
  output logic [AW-1:0]     rec_addr
);

  logic              cap, load;
  logic [1:0]        status_d, status_q;
  logic [ID_W-1:0]   id_d, id_q;
  logic [MODE_W-1:0] mode_d, mode_q;
  logic [NREG-1:0]   map_d, map_q;
  logic [AW-1:0]     addr_d, addr_q;

  always_comb begin
    cap  = viol && ((status_q == EXC_NONE) || clr);
    load = cap || clr;
    if (cap) begin
      status_d = type_in;
      id_d     = id_in;
      mode_d   = mode_in;
      map_d    = map_in;
      addr_d   = addr_in;
    end else begin
      status_d = EXC_NONE;
      id_d     = '0;
      mode_d   = '0;
      map_d    = '0;
      addr_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= EXC_NONE;
      id_q     <= '0;
      mode_q   <= '0;
      map_q    <= '0;
      addr_q   <= '0;
    end else if (load) begin
      status_q <= status_d;
      id_q     <= id_d;
      mode_q   <= mode_d;
      map_q    <= map_d;
      addr_q   <= addr_d;
    end
  end

  assign status   = status_q;
  assign rec_id   = id_q;
  assign rec_mode = mode_q;
  assign rec_map  = map_q;
  assign rec_addr = addr_q;

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_q)); // R6

  AST_HOLD_INFO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != EXC_NONE && !clr) |=> ($stable(status_q) && $stable(id_q) && $stable(addr_q) && $stable(map_q))); // R8

  AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !viol) |=> (status_q == EXC_NONE)); // R9

endmodule

// File: rtl/perm_cfg_regs.sv
module perm_cfg_regs
  import perm_chk_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int NPATH = 2,
  parameter int AW    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [11:0]                   addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic [NREG-1:0][AW-1:0]       rg_lo,
  output logic [NREG-1:0][AW-1:0]       rg_hi,
  output logic [NREG-1:0][2:0][2:0]     rg_attr,
  output logic [NREG-1:0]               rg_en,
  output logic [NPATH-1:0]              path_en,
  output logic [NPATH-1:0]              irq_en,
  output logic [NMAST-1:0][MODE_W-1:0]  mode_tab,
  output logic [NPATH-1:0]              clr_pulse,
  input  logic [NPATH-1:0][1:0]         st_in,
  input  logic [NPATH-1:0][31:0]        info0_in,
  input  logic [NPATH-1:0][AW-1:0]      info1_in
);

  localparam int RIX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int PIX_W = (NPATH > 1) ? $clog2(NPATH) : 1;

  logic [NREG-1:0][AW-1:0]      lo_d, lo_q, hi_d, hi_q;
  logic [NREG-1:0][2:0][2:0]    attr_d, attr_q;
  logic [NREG-1:0]              en_d, en_q;
  logic [NPATH-1:0]             pen_d, pen_q, ien_d, ien_q;
  logic [NMAST-1:0][MODE_W-1:0] mode_d, mode_q;

  logic             aligned, rg_ok, pt_ok;
  logic [RIX_W-1:0] rix;
  logic [PIX_W-1:0] pix;
  logic [3:0]       blk;

  assign blk     = addr[11:8];
  assign aligned = (addr[1:0] == 2'b00);
  assign rg_ok   = (int'(addr[7:4]) < NREG);
  assign pt_ok   = (int'(addr[7:4]) < NPATH);
  assign rix     = addr[4 +: RIX_W];
  assign pix     = addr[4 +: PIX_W];

  // next state of the configuration registers and clear pulses
  always_comb begin
    lo_d      = lo_q;
    hi_d      = hi_q;
    attr_d    = attr_q;
    en_d      = en_q;
    pen_d     = pen_q;
    ien_d     = ien_q;
    mode_d    = mode_q;
    clr_pulse = '0;
    if (we && aligned) begin
      case (blk)
        BLK_CTRL: begin
          case (addr[7:2])
            6'd0:    en_d  = wdata[NREG-1:0];
            6'd1:    pen_d = wdata[NPATH-1:0];
            6'd2:    ien_d = wdata[NPATH-1:0];
            default: ;
          endcase
        end
        BLK_REGION: begin
          if (rg_ok) begin
            case (addr[3:2])
              2'd0: lo_d[rix] = wdata[AW-1:0];
              2'd1: hi_d[rix] = wdata[AW-1:0];
              2'd2: begin
                attr_d[rix][0] = wdata[2:0];
                attr_d[rix][1] = wdata[6:4];
                attr_d[rix][2] = wdata[10:8];
              end
              default: ;
            endcase
          end
        end
        BLK_PATH: begin
          if (pt_ok && addr[3:2] == 2'd1) clr_pulse[pix] = wdata[0];
        end
        BLK_MODE: begin
          if (!addr[7]) mode_d[addr[6:2]] = wdata[MODE_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      attr_q <= '0;
      en_q   <= '0;
      pen_q  <= '0;
      ien_q  <= '0;
      mode_q <= '0;
    end else if (we) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      attr_q <= attr_d;
      en_q   <= en_d;
      pen_q  <= pen_d;
      ien_q  <= ien_d;
      mode_q <= mode_d;
    end
  end

  // combinational read mux
  always_comb begin
    rdata = '0;
    case (blk)
      BLK_CTRL: begin
        case (addr[7:2])
          6'd0:    rdata[NREG-1:0]  = en_q;
          6'd1:    rdata[NPATH-1:0] = pen_q;
          6'd2:    rdata[NPATH-1:0] = ien_q;
          default: ;
        endcase
      end
      BLK_REGION: begin
        if (rg_ok) begin
          case (addr[3:2])
            2'd0:    rdata[AW-1:0] = lo_q[rix];
            2'd1:    rdata[AW-1:0] = hi_q[rix];
            2'd2:    rdata = {21'b0, attr_q[rix][2], 1'b0, attr_q[rix][1], 1'b0, attr_q[rix][0]};
            default: ;
          endcase
        end
      end
      BLK_PATH: begin
        if (pt_ok) begin
          case (addr[3:2])
            2'd0:    rdata[1:0]    = st_in[pix];
            2'd2:    rdata         = info0_in[pix];
            2'd3:    rdata[AW-1:0] = info1_in[pix];
            default: ;
          endcase
        end
      end
      BLK_MODE: begin
        if (!addr[7]) rdata[MODE_W-1:0] = mode_q[addr[6:2]];
      end
      default: ;
    endcase
  end

  assign rg_lo    = lo_q;
  assign rg_hi    = hi_q;
  assign rg_attr  = attr_q;
  assign rg_en    = en_q;
  assign path_en  = pen_q;
  assign irq_en   = ien_q;
  assign mode_tab = mode_q;

endmodule

// File: rtl/perm_checker.sv
module perm_checker
  import perm_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_PATHS   = 2,
  parameter int ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [11:0]                   cfg_addr,
  input  logic [31:0]                   cfg_wdata,
  output logic [31:0]                   cfg_rdata,
  input  logic [NUM_PATHS-1:0]          acc_valid,
  input  logic [NUM_PATHS*ADDR_W-1:0]   acc_addr,
  input  logic [NUM_PATHS*ID_W-1:0]     acc_id,
  input  logic [NUM_PATHS*2-1:0]        acc_kind,
  output logic [NUM_PATHS-1:0]          acc_allow,
  output logic [NUM_PATHS-1:0]          acc_block,
  output logic [NUM_PATHS-1:0]          irq
);

  localparam int MAP_W = 16;

  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  rg_lo, rg_hi;
  logic [NUM_REGIONS-1:0][2:0][2:0]    rg_attr;
  logic [NUM_REGIONS-1:0]              rg_en;
  logic [NUM_PATHS-1:0]                path_en, irq_en, clr_pulse;
  logic [NMAST-1:0][MODE_W-1:0]        mode_tab;
  logic [NUM_PATHS-1:0][1:0]           st;
  logic [NUM_PATHS-1:0][31:0]          info0;
  logic [NUM_PATHS-1:0][ADDR_W-1:0]    info1;

  perm_cfg_regs #(.NREG(NUM_REGIONS), .NPATH(NUM_PATHS), .AW(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .rg_lo     (rg_lo),
    .rg_hi     (rg_hi),
    .rg_attr   (rg_attr),
    .rg_en     (rg_en),
    .path_en   (path_en),
    .irq_en    (irq_en),
    .mode_tab  (mode_tab),
    .clr_pulse (clr_pulse),
    .st_in     (st),
    .info0_in  (info0),
    .info1_in  (info1)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic [ADDR_W-1:0]      a;
    logic [ID_W-1:0]        id;
    logic [MODE_W-1:0]      md;
    logic [NUM_REGIONS-1:0] hits, rmap;
    logic                   ok, viol;
    logic [1:0]             ek;
    logic [ID_W-1:0]        rid;
    logic [MODE_W-1:0]      rmd;
    logic [MAP_W-1:0]       map16;

    assign a  = acc_addr[p*ADDR_W +: ADDR_W];
    assign id = acc_id[p*ID_W +: ID_W];
    assign md = mode_tab[id];

    perm_region_eval #(.NREG(NUM_REGIONS), .AW(ADDR_W)) u_eval (
      .addr     (a),
      .mode     (md),
      .kind     (acc_kind[p*2 +: 2]),
      .rg_lo    (rg_lo),
      .rg_hi    (rg_hi),
      .rg_attr  (rg_attr),
      .rg_en    (rg_en),
      .hit_map  (hits),
      .ok       (ok),
      .exc_kind (ek)
    );

    assign viol         = acc_valid[p] && path_en[p] && !ok;
    assign acc_block[p] = viol;
    assign acc_allow[p] = acc_valid[p] && !viol;

    perm_exc_rec #(.NREG(NUM_REGIONS), .AW(ADDR_W)) u_rec (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .viol     (viol),
      .clr      (clr_pulse[p]),
      .type_in  (ek),
      .id_in    (id),
      .mode_in  (md),
      .map_in   (hits),
      .addr_in  (a),
      .status   (st[p]),
      .rec_id   (rid),
      .rec_mode (rmd),
      .rec_map  (rmap),
      .rec_addr (info1[p])
    );

    always_comb begin
      map16                  = '0;
      map16[NUM_REGIONS-1:0] = rmap;
      info0[p]               = {9'b0, rid, rmd, map16};
    end

    assign irq[p] = irq_en[p] && (st[p] != EXC_NONE);

    AST_TRUSTED_PASS: assert property (@(posedge clk) disable iff (!rst_i_n)
      (acc_valid[p] && md == 2'd0) |-> acc_allow[p]); // R4

    AST_BLOCK_RECORDS: assert property (@(posedge clk) disable iff (!rst_i_n)
      acc_block[p] |=> (st[p] != EXC_NONE)); // R6
  end

endmodule

// File: tb/perm_checker_test.sv
module perm_checker_test;

  localparam int CLK_P = 10;
  localparam int NP    = 2;
  localparam int AW    = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [11:0]       cfg_addr;
  logic [31:0]       cfg_wdata;
  logic [31:0]       cfg_rdata;
  logic [NP-1:0]     acc_valid;
  logic [NP*AW-1:0]  acc_addr;
  logic [NP*5-1:0]   acc_id;
  logic [NP*2-1:0]   acc_kind;
  logic [NP-1:0]     acc_allow, acc_block, irq;

  int n_chk = 0;
  int n_err = 0;

  typedef struct { int p; bit allow; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  perm_checker #(.NUM_REGIONS(4), .NUM_PATHS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_id(acc_id), .acc_kind(acc_kind),
    .acc_allow(acc_allow), .acc_block(acc_block), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #(CLK_P/4);
    v = cfg_rdata;
  endtask

  task automatic rchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic put(input int p, input logic [31:0] a, input logic [4:0] id, input logic [1:0] k);
    acc_valid[p] = 1'b1;
    acc_addr[p*AW +: AW] = a;
    acc_id[p*5 +: 5] = id;
    acc_kind[p*2 +: 2] = k;
  endtask

  // driver: one access, expected outcome pushed to the scoreboard
  task automatic acc(input int p, input logic [31:0] a, input logic [4:0] id,
                     input logic [1:0] k, input bit allow, input string tag);
    @(negedge clk);
    put(p, a, id, k);
    sb.push_back('{p, allow, tag});
    @(negedge clk);
    acc_valid[p] = 1'b0;
  endtask

  // monitor: compare in the sampling slot after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " allow"}, {31'b0, acc_allow[e.p]}, {31'b0, e.allow});
        chk({e.tag, " block"}, {31'b0, acc_block[e.p]}, {31'b0, !e.allow});
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P*100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    acc_valid = '0; acc_addr = '0; acc_id = '0; acc_kind = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rchk(12'h000, 32'h0, "R1 region enable");
    rchk(12'h200, 32'h0, "R1 status p0");
    rchk(12'h208, 32'h0, "R1 info0 p0");
    chk("R1 irq", {30'b0, irq}, 32'h0);
    acc(0, 32'h1000, 5'd3, 2'd2, 1'b1, "R1 unchecked path after reset");

    // mode table and windows
    wr(12'h30C, 32'd1);
    wr(12'h310, 32'd2);
    wr(12'h314, 32'd3);
    rchk(12'h30C, 32'd1, "R11 mode entry");
    wr(12'h100, 32'h1000); wr(12'h104, 32'h1FFF); wr(12'h108, 32'h043);
    wr(12'h110, 32'h1800); wr(12'h114, 32'h27FF); wr(12'h118, 32'h100);
    wr(12'h120, 32'h5000); wr(12'h124, 32'h50FF); wr(12'h128, 32'hFFFF_FFFF);
    rchk(12'h108, 32'h043, "R11 attr readback");
    rchk(12'h128, 32'h777, "R11 attr unused bits zero");
    rchk(12'h114, 32'h27FF, "R11 end readback");
    wr(12'h000, 32'h3);
    wr(12'h004, 32'h3);
    wr(12'h008, 32'h1);

    // R2 bounds inclusive
    acc(0, 32'h1000, 5'd3, 2'd0, 1'b1, "R2 start bound");
    acc(0, 32'h1FFF, 5'd3, 2'd1, 1'b1, "R2 end bound");
    // R3 denied right -> status 2
    acc(0, 32'h1000, 5'd3, 2'd2, 1'b0, "R3 exec denied mode1");
    rchk(12'h200, 32'd2, "R6 status denied");
    rchk(12'h208, 32'h000D_0001, "R7 info0");
    rchk(12'h20C, 32'h1000, "R7 info1");
    chk("R10 irq p0 set", {31'b0, irq[0]}, 32'd1);

    // R8 later violation held off
    acc(0, 32'h0100, 5'd4, 2'd0, 1'b0, "R8 later violation blocked");
    rchk(12'h200, 32'd2, "R8 status kept");
    rchk(12'h208, 32'h000D_0001, "R8 info0 kept");
    rchk(12'h20C, 32'h1000, "R8 info1 kept");

    // R9 clear
    wr(12'h204, 32'h0);
    rchk(12'h200, 32'd2, "R9 clear bit0 low ignored");
    wr(12'h204, 32'h1);
    rchk(12'h200, 32'd0, "R9 status cleared");
    rchk(12'h208, 32'd0, "R9 info cleared");
    chk("R10 irq p0 cleared", {31'b0, irq[0]}, 32'd0);

    // R4 trusted
    acc(0, 32'h9000, 5'd0, 2'd2, 1'b1, "R4 trusted mode");
    rchk(12'h200, 32'd0, "R4 no record for trusted");

    // R3 overlap, path 1, interrupt masked
    acc(1, 32'h1900, 5'd5, 2'd0, 1'b1, "R3 overlap grant mode3");
    acc(1, 32'h1004, 5'd4, 2'd2, 1'b1, "R3 exec mode2");
    acc(1, 32'h1900, 5'd5, 2'd1, 1'b0, "R3 write denied mode3");
    rchk(12'h210, 32'd2, "R6 status p1");
    rchk(12'h218, 32'h0017_0003, "R7 info0 hit map two windows");
    chk("R10 irq p1 masked", {31'b0, irq[1]}, 32'd0);
    rchk(12'h200, 32'd0, "R6 path0 independent");
    acc(0, 32'h1000, 5'd3, 2'd3, 1'b0, "R3 reserved kind");
    wr(12'h204, 32'h1);

    // R2 disabled window -> no match
    acc(0, 32'h5010, 5'd5, 2'd0, 1'b0, "R2 disabled window");
    rchk(12'h200, 32'd1, "R6 status no match");
    rchk(12'h208, 32'h0017_0000, "R7 info0 empty map");
    rchk(12'h20C, 32'h5010, "R7 info1 addr");

    // R9 clear and violation in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 12'h204; cfg_wdata = 32'h1;
    put(0, 32'h1000, 5'd4, 2'd0);
    sb.push_back('{0, 1'b0, "R9 same-cycle violation"});
    @(negedge clk);
    cfg_we = 1'b0; acc_valid[0] = 1'b0;
    rchk(12'h200, 32'd2, "R9 new fault wins over clear");
    rchk(12'h208, 32'h0012_0001, "R9 new fault info0");

    // R5 filter off
    wr(12'h204, 32'h1);
    wr(12'h004, 32'h2);
    acc(0, 32'h0000, 5'd4, 2'd0, 1'b1, "R5 filter off pass");
    rchk(12'h200, 32'd0, "R5 no record when filter off");
    acc(1, 32'h0000, 5'd4, 2'd0, 1'b0, "R5 other path still checked");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule